// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces a periodic rectangular pulse on one output pin. A counter advances on each cycle where the count-enable tick is high. When the counter reaches the value held in the period register, it returns to zero on the next tick and carries on counting. A second compare value, the width, sets where the pulse changes level inside each period. One output flip-flop creates the waveform. It inverts on the tick where the count equals the width, and again on the tick where the count equals the period. Its level at the start of each period is therefore the level that software preset before it started the timer.

Software stops the timer and loads both compare values through a shared data bus with two write strobes. It then presets the flip-flop level with a set strobe or a clear strobe, and starts the timer. The period lasts period+1 ticks. The preset level lasts width+1 ticks of that period, so the duty is (width+1)/(period+1) when the preset level is 1. Compare values written while the timer runs are kept in shadow registers and take effect at the next counter clear. A legal setting needs a non-zero width that is strictly below the period. An error flag reports whether the most recent write left an illegal pair.

Top module: `ppg_timer`

## Requirements
- R1: While running, the counter advances by one only on cycles with `tick` high. On a tick where the count equals the active period P, it clears to 0. The waveform therefore repeats every P+1 ticks, and cycles without a tick change nothing.
- R2: The output flip-flop inverts on the edge of a tick where the count equals the active width W. The new level is visible from the following cycle.
- R3: The output flip-flop also inverts on the edge of the tick where the count equals P. Starting from a preset level L at count 0, the output is L for W+1 ticks and the opposite of L for P-W ticks.
- R4: While stopped, `lvlSet` alone forces the flip-flop to 1 and `lvlClr` alone forces it to 0, one edge later. Both high together leaves it unchanged. Both strobes are ignored while running.
- R5: `pulseOut` equals the flip-flop when `outEn` is 1 and equals the idle level (parameter, default 0) when `outEn` is 0. It follows `outEn` in the same cycle.
- R6: `cfgErr` is updated on the edge of any compare write. It becomes 1 exactly when the resulting shadow pair fails 0 < W < P, and 0 otherwise. Between writes it holds, and it resets to 0.
- R7: Compare writes made while running reach the active registers only on the tick where the counter clears. The period in progress completes with the old values.
- R8: While stopped, the counter is held at 0, the active registers copy the shadow registers one edge after a write, and the flip-flop keeps its level. A restart begins at count 0 from that level.
- R9: After reset the flip-flop is 0, the counter is 0, all compare registers are 0 and `cfgErr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | 1 runs the timer, 0 stops it |
| tick | input | 1 | Count-enable tick |
| perWrEn | input | 1 | Write `wrData` into the period shadow register |
| widWrEn | input | 1 | Write `wrData` into the width shadow register |
| wrData | input | CNT_W | Compare write data |
| lvlSet | input | 1 | Preset flip-flop to 1 (stopped only) |
| lvlClr | input | 1 | Preset flip-flop to 0 (stopped only) |
| outEn | input | 1 | Output enable |
| pulseOut | output | 1 | Pulse output pin |
| cfgErr | output | 1 | Illegal compare pair flag |

## Verification
The flip-flop, the counter, the active registers and `cfgErr` each change on the first clock edge after the stimulus that causes them. The pin is combinational from `outEn` and the flip-flop, so a change of `outEn` shows within the same cycle. The bench drives every input on the falling edge and samples on the next falling edge, one rising edge later. A phase model in the bench advances only on ticked cycles, so each sample is compared with the level due after exactly the ticks counted so far. The bench uses a 5-bit counter. It sweeps every legal width and period pair, and every one of the 1024 raw pairs for the error flag.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic cntZero;    // hold counter at zero (timer stopped)
    logic cntInc;     // advance counter by one
    logic cntWrap;    // clear counter after a period match
    logic actLoad;    // copy shadow compare values into active set
    logic ffToggle;   // invert output flip-flop
    logic ffSet;      // preset output flip-flop to 1
    logic ffClr;      // preset output flip-flop to 0
    logic errUpdate;  // re-evaluate compare legality
  } ppgStrb_t;

  localparam int NCMP     = 2;
  localparam int CMP_PER  = 0;
  localparam int CMP_WID  = 1;

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
(
  input  logic     runEn,
  input  logic     tick,
  input  logic     lvlSet,
  input  logic     lvlClr,
  input  logic     perWrEn,
  input  logic     widWrEn,
  input  logic     matchPer,
  input  logic     matchWid,
  output ppgStrb_t strb
);

  logic stepNow;
  logic presetOk;

  // A counting step happens only on a ticked cycle of a running timer.
  assign stepNow  = runEn & tick;
  // Preset strobes act only while stopped and only if exactly one is high.
  assign presetOk = ~runEn & (lvlSet ^ lvlClr);

  always_comb begin
    strb           = '0;
    strb.cntZero   = ~runEn;
    strb.cntWrap   = stepNow & matchPer;
    strb.cntInc    = stepNow & ~matchPer;
    strb.actLoad   = ~runEn | (stepNow & matchPer);
    // Equal compare values would cancel; xor keeps a single inversion rule.
    strb.ffToggle  = stepNow & (matchPer ^ matchWid);
    strb.ffSet     = presetOk & lvlSet;
    strb.ffClr     = presetOk & lvlClr;
    strb.errUpdate = perWrEn | widWrEn;
  end

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppgStrb_t         strb,
  input  logic             perWrEn,
  input  logic             widWrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic             matchPer,
  output logic             matchWid,
  output logic             ffQ,
  output logic             cfgErr
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shadowVal [NCMP];
  logic [CNT_W-1:0] shadowNxt [NCMP];
  logic [CNT_W-1:0] activeVal [NCMP];
  logic [NCMP-1:0]  cmpHit;
  logic [NCMP-1:0]  wrSel;

  assign wrSel[CMP_PER] = perWrEn;
  assign wrSel[CMP_WID] = widWrEn;

  // One shadow register, one active register and one comparator per channel.
  for (genvar g = 0; g < NCMP; g++) begin : gCmp
    assign shadowNxt[g] = wrSel[g] ? wrData : shadowVal[g];
    assign cmpHit[g]    = (cnt == activeVal[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowVal[g] <= ZERO;
        activeVal[g] <= ZERO;
      end else begin
        shadowVal[g] <= shadowNxt[g];
        if (strb.actLoad) activeVal[g] <= shadowVal[g];
      end
    end
  end

  assign matchPer = cmpHit[CMP_PER];
  assign matchWid = cmpHit[CMP_WID];

  // Counter: held at zero when stopped, clear-and-start on period match.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cnt <= ZERO;
    else if (strb.cntZero || strb.cntWrap) cnt <= ZERO;
    else if (strb.cntInc)                  cnt <= cnt + ONE;
  end

  // Output flip-flop: preset while stopped, inverted on compare matches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ffQ <= 1'b0;
    else if (strb.ffSet)    ffQ <= 1'b1;
    else if (strb.ffClr)    ffQ <= 1'b0;
    else if (strb.ffToggle) ffQ <= ~ffQ;
  end

  function automatic logic pairBad(input logic [CNT_W-1:0] per,
                                   input logic [CNT_W-1:0] wid);
    return (wid == ZERO) || (wid >= per);
  endfunction

  // Legality is judged on the pair the write leaves behind.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgErr <= 1'b0;
    else if (strb.errUpdate) cfgErr <= pairBad(shadowNxt[CMP_PER], shadowNxt[CMP_WID]);
  end

  // R1: count never exceeds the active period
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= activeVal[CMP_PER]);

  // R1: without a step the count does not move
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntInc && !strb.cntWrap && !strb.cntZero) |=> $stable(cnt));

  // R8: stopped timer leaves counter at zero
  assert_stop_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntZero |=> (cnt == ZERO));

  // R7: active compare values change only at a load point
  assert_active_defer_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.actLoad |=> ($stable(activeVal[CMP_PER]) && $stable(activeVal[CMP_WID])));

  // R6: flag after a write matches legality of the shadow pair
  assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.errUpdate |=> (cfgErr == ((shadowVal[CMP_WID] == ZERO) ||
                                   (shadowVal[CMP_WID] >= shadowVal[CMP_PER]))));

  // R6: flag holds between writes
  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.errUpdate |=> $stable(cfgErr));

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int   CNT_W    = 16,
  parameter logic PIN_IDLE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             tick,
  input  logic             perWrEn,
  input  logic             widWrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             lvlSet,
  input  logic             lvlClr,
  input  logic             outEn,
  output logic             pulseOut,
  output logic             cfgErr
);

  ppgStrb_t strb;
  logic     matchPer;
  logic     matchWid;
  logic     ffQ;

  ppg_ctrl uCtrl (
    .runEn    (runEn),
    .tick     (tick),
    .lvlSet   (lvlSet),
    .lvlClr   (lvlClr),
    .perWrEn  (perWrEn),
    .widWrEn  (widWrEn),
    .matchPer (matchPer),
    .matchWid (matchWid),
    .strb     (strb)
  );

  ppg_datapath #(.CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .perWrEn  (perWrEn),
    .widWrEn  (widWrEn),
    .wrData   (wrData),
    .matchPer (matchPer),
    .matchWid (matchWid),
    .ffQ      (ffQ),
    .cfgErr   (cfgErr)
  );

  assign pulseOut = outEn ? ffQ : PIN_IDLE;

  // R5: disabled pin sits at its idle level
  assert_pin_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (pulseOut == PIN_IDLE));

  // R4: while running, level changes only on ticked cycles
  assert_run_ignore_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !tick) |=> $stable(ffQ));

  // R4/R8: stopped with no single preset strobe keeps the level
  assert_stop_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !(lvlSet ^ lvlClr)) |=> $stable(ffQ));

  // R4: a lone preset strobe while stopped sets the requested level
  assert_preset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && (lvlSet ^ lvlClr)) |=> (ffQ == $past(lvlSet)));

endmodule

// File: tb/tb_ppg_timer.sv
module tb_ppg_timer;

  localparam int CW   = 5;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runEn = 1'b0, tick = 1'b0;
  logic          perWrEn = 1'b0, widWrEn = 1'b0;
  logic [CW-1:0] wrData = '0;
  logic          lvlSet = 1'b0, lvlClr = 1'b0, outEn = 1'b0;
  logic          pulseOut, cfgErr;
  logic [15:0]   lfsr = 16'hACE1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ppg_timer #(.CNT_W(CW), .PIN_IDLE(1'b0)) dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .tick(tick),
    .perWrEn(perWrEn), .widWrEn(widWrEn), .wrData(wrData),
    .lvlSet(lvlSet), .lvlClr(lvlClr), .outEn(outEn),
    .pulseOut(pulseOut), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic writeRegs(input int p, input int w);
    perWrEn = 1'b1; wrData = CW'(p); cyc(); perWrEn = 1'b0;
    widWrEn = 1'b1; wrData = CW'(w); cyc(); widWrEn = 1'b0;
  endtask

  task automatic preset(input bit l);
    lvlSet = l; lvlClr = !l; cyc(); lvlSet = 1'b0; lvlClr = 1'b0;
  endtask

  // Full waveform run; rnd adds sparse ticks, outEn changes and ignored presets.
  task automatic runPair(input int p, input int w, input bit l, input bit rnd);
    int  ph    = 0;
    int  steps = rnd ? 4 * (p + 1) : 2 * (p + 1) + 1;
    bit  t, oe, exp;
    runEn = 1'b0;
    writeRegs(p, w);
    chk(cfgErr == 1'b0, "R6 legal pair", cfgErr, 0);
    outEn = 1'b1;
    preset(l);
    chk(pulseOut == l, "R4 preset level", pulseOut, l);
    for (int s = 0; s < steps; s++) begin
      t  = rnd ? lfsr[0] : 1'b1;
      oe = rnd ? (lfsr[3] | lfsr[5]) : 1'b1;
      tick = t; outEn = oe; runEn = 1'b1;
      if (rnd) begin lvlSet = lfsr[7]; lvlClr = lfsr[9]; end
      cyc();
      stepLfsr();
      if (t) ph = (ph == p) ? 0 : ph + 1;
      exp = oe ? (l ^ (ph > w)) : 1'b0;
      if (rnd) chk(pulseOut == exp, "R1/R4/R5 sparse ticks", pulseOut, exp);
      else     chk(pulseOut == exp, "R2/R3 waveform", pulseOut, exp);
    end
    tick = 1'b0; lvlSet = 1'b0; lvlClr = 1'b0; outEn = 1'b1; runEn = 1'b0;
    cyc();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ph, pc, wc, pn, wn;
    bit lv, exp;
    @(negedge clk); @(negedge clk);
    outEn = 1'b1;
    cyc();
    // R9: reset state at the pins
    chk(pulseOut == 1'b0, "R9 reset pin", pulseOut, 0);
    chk(cfgErr == 1'b0, "R9 reset flag", cfgErr, 0);
    rstN = 1'b1;
    cyc();
    chk(pulseOut == 1'b0, "R9 after release", pulseOut, 0);

    // R4: both strobes together are ignored while stopped
    preset(1'b1);
    lvlSet = 1'b1; lvlClr = 1'b1; cyc(); lvlSet = 1'b0; lvlClr = 1'b0;
    chk(pulseOut == 1'b1, "R4 both strobes hold 1", pulseOut, 1);
    preset(1'b0);
    lvlSet = 1'b1; lvlClr = 1'b1; cyc(); lvlSet = 1'b0; lvlClr = 1'b0;
    chk(pulseOut == 1'b0, "R4 both strobes hold 0", pulseOut, 0);

    // R5: disabling the pin shows idle level in the same cycle
    preset(1'b1);
    outEn = 1'b0; cyc();
    chk(pulseOut == 1'b0, "R5 disabled pin", pulseOut, 0);
    outEn = 1'b1; cyc();
    chk(pulseOut == 1'b1, "R5 enabled pin", pulseOut, 1);

    // R6: every raw pair, flag due one edge after the last write
    for (int p = 0; p <= MAXV; p++) begin
      for (int w = 0; w <= MAXV; w++) begin
        writeRegs(p, w);
        exp = (w == 0) || (w >= p);
        chk(cfgErr == exp, "R6 pair legality", cfgErr, exp);
      end
    end
    writeRegs(3, 3);
    cyc(); cyc();
    chk(cfgErr == 1'b1, "R6 flag holds", cfgErr, 1);

    // R1/R2/R3: every legal pair with full ticks, both preset levels
    for (int p = 2; p <= MAXV; p++) begin
      for (int w = 1; w < p; w++) begin
        runPair(p, w, 1'((p + w) & 1), 1'b0);
      end
    end
    // R1/R4/R5: sparse ticks with ignored presets and gated pin
    for (int p = 2; p <= MAXV; p += 3) begin
      for (int w = 1; w < p; w += 2) begin
        runPair(p, w, 1'(w & 1), 1'b1);
      end
    end

    // R7: writes during a run wait for the next counter clear
    writeRegs(10, 3);
    preset(1'b1);
    pc = 10; wc = 3; pn = 10; wn = 3; ph = 0;
    for (int s = 0; s < 60; s++) begin
      runEn = 1'b1; tick = 1'b1;
      perWrEn = (s == 4); widWrEn = (s == 5);
      wrData = (s == 4) ? CW'(6) : CW'(2);
      cyc();
      perWrEn = 1'b0; widWrEn = 1'b0;
      if (ph == pc) begin ph = 0; pc = pn; wc = wn; end
      else ph++;
      if (s == 4) pn = 6;
      if (s == 5) wn = 2;
      exp = 1'b1 ^ (ph > wc);
      chk(pulseOut == exp, "R7 deferred compare", pulseOut, exp);
    end
    runEn = 1'b0; tick = 1'b0; cyc();

    // R8: stop mid-period keeps level, restart from count zero
    writeRegs(8, 3);
    preset(1'b0);
    runEn = 1'b1; tick = 1'b1;
    for (int s = 0; s < 6; s++) cyc();
    runEn = 1'b0; tick = 1'b1;
    cyc(); cyc();
    chk(pulseOut == 1'b1, "R8 stopped level held", pulseOut, 1);
    lv = 1'b1; ph = 0;
    for (int s = 0; s < 20; s++) begin
      runEn = 1'b1; tick = 1'b1;
      cyc();
      ph = (ph == 8) ? 0 : ph + 1;
      exp = lv ^ (ph > 3);
      chk(pulseOut == exp, "R8 restart from zero", pulseOut, exp);
    end
    runEn = 1'b0; tick = 1'b0; cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule